// File: doc/BRIEF.md
# Receive Character Queue with Selectable Ready Threshold

This block stores received characters between a serial receiver and a host. The receiver hands in one byte per push. The host takes bytes out in the order they arrived. The oldest stored byte is always present on the read data output. The host's pop strobe consumes that byte and brings the next one forward. The queue holds 8 or 16 entries, chosen by a parameter.

Instead of signalling as soon as any byte is present, the block raises a receive-ready request once the fill level reaches a chosen threshold. The threshold comes from a two-bit select. Each bit of the select lives in a different mode register outside this block. The four trigger points depend on the depth.

The block also reports its fill count, empty and full flags, and a sticky overflow flag. The overflow flag records a byte that arrived with no room left. Interrupt masking and the deserializer sit outside the block.

Top module: `rx_trigger_fifo`

## Requirements
- R1: After reset, fillCount is 0, isEmpty is 1, isFull is 0, overflowFlag is 0 and rxReady is 0.
- R2: Bytes leave in the order they were accepted. While the queue is not empty, hostData shows the oldest stored byte. A pop removes that byte at the next clock edge.
- R3: fillCount equals the number of stored bytes, from 0 to DEPTH. isEmpty is 1 exactly when fillCount is 0, and isFull is 1 exactly when fillCount equals DEPTH.
- R4: The threshold select is {trigSelHi, trigSelLo}, with trigSelHi as the upper bit. With DEPTH 8, the values 00, 01, 10 and 11 give thresholds of 1, 3, 6 and 8 bytes.
- R5: With DEPTH 16, the select values 00, 01, 10 and 11 give thresholds of 1, 6, 12 and 16 bytes.
- R6: rxReady is 1 exactly when fillCount is at or above the selected threshold. It follows a change of the select inputs in the same cycle, without waiting for a clock edge.
- R7: A push while the queue is full and no pop is requested discards the byte. fillCount stays the same, the stored contents are unchanged, and overflowFlag is set.
- R8: overflowFlag stays set until reset or a cycle with ovfClear high. A discarded push in the same cycle as ovfClear leaves the flag set.
- R9: A push and a pop in the same cycle on a non-empty queue both take effect and leave fillCount unchanged. This holds when the queue is full as well: the byte is accepted and no overflow is flagged.
- R10: A pop on an empty queue is ignored: fillCount stays 0 and the next accepted byte is the next one popped. A push and a pop together on an empty queue store the byte, so fillCount becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxPush | input | 1 | Receiver offers a byte this cycle |
| rxData | input | DATA_W | Byte offered by the receiver |
| hostPop | input | 1 | Host consumes the oldest byte this cycle |
| hostData | output | DATA_W | Oldest stored byte |
| trigSelHi | input | 1 | Upper threshold select bit |
| trigSelLo | input | 1 | Lower threshold select bit |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| fillCount | output | $clog2(DEPTH+1) | Number of stored bytes |
| isEmpty | output | 1 | No byte stored |
| isFull | output | 1 | All DEPTH entries used |
| overflowFlag | output | 1 | Sticky flag for a discarded byte |
| rxReady | output | 1 | Fill level is at or above the selected threshold |

## Verification
The bench builds two copies of the block side by side, one with DEPTH 8 and one with DEPTH 16. Both copies are driven by the same stimulus.

With sixteen pushes in a row, the 8-deep copy overflows halfway through, while the 16-deep copy keeps filling to its own limit. At every fill level from 0 to 16, all four select values are swept on both copies. This covers both threshold tables and every boundary of the ready comparison.

The shared stimulus also reaches a simultaneous push and pop on a full queue in both copies. It reaches a pop on an empty queue as well, and an overflow clear that collides with a new discarded byte.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes from control to storage for one cycle
  typedef struct packed {
    logic wrEn;       // store the incoming byte and advance the write pointer
    logic rdEn;       // advance the read pointer
    logic dropWrite;  // incoming byte discarded (queue full)
  } rxqStrobes_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqStrobes_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= nextPtr(wrPtr);
      if (stb.rdEn) rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrPtr] <= wrData;
  end

  // First-word fall-through: the oldest entry is always presented
  assign rdData = mem[rdPtr];

  // A discarded byte must never also be written
  assert_drop_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrEn && stb.dropWrite));

  // A write strobe moves the write pointer by exactly one slot
  assert_wr_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> wrPtr != $past(wrPtr) || DEPTH == 1);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             ovfClear,
  input  logic             selHi,
  input  logic             selLo,
  output rxqStrobes_t      stb,
  output logic [CNT_W-1:0] fillCount,
  output logic             isEmpty,
  output logic             isFull,
  output logic             overflowFlag,
  output logic             rxReady
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] countQ;
  logic             ovfQ;
  logic             rdOk;
  logic             wrOk;
  logic [1:0]       sel;
  logic [CNT_W-1:0] threshold;

  assign isEmpty = (countQ == '0);
  assign isFull  = (countQ == FULL_CNT);

  // A pop on an empty queue does nothing; a pop on a full queue frees the slot
  assign rdOk = pop && !isEmpty;
  assign wrOk = push && (!isFull || rdOk);

  always_comb begin
    stb           = '0;
    stb.wrEn      = wrOk;
    stb.rdEn      = rdOk;
    stb.dropWrite = push && !wrOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else begin
      unique case ({wrOk, rdOk})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  // Sticky overflow; a new discard wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ovfQ <= 1'b0;
    else if (stb.dropWrite) ovfQ <= 1'b1;
    else if (ovfClear)      ovfQ <= 1'b0;
  end

  assign sel = {selHi, selLo};

  generate
    if (DEPTH == 16) begin : g_thr16
      always_comb begin
        unique case (sel)
          2'b00:   threshold = CNT_W'(1);
          2'b01:   threshold = CNT_W'(6);
          2'b10:   threshold = CNT_W'(12);
          default: threshold = CNT_W'(16);
        endcase
      end
    end else if (DEPTH == 8) begin : g_thr8
      always_comb begin
        unique case (sel)
          2'b00:   threshold = CNT_W'(1);
          2'b01:   threshold = CNT_W'(3);
          2'b10:   threshold = CNT_W'(6);
          default: threshold = CNT_W'(8);
        endcase
      end
    end else begin : g_thrScaled
      always_comb begin
        unique case (sel)
          2'b00:   threshold = CNT_W'(1);
          2'b01:   threshold = CNT_W'((DEPTH > 3) ? DEPTH / 4 : 1);
          2'b10:   threshold = CNT_W'((DEPTH > 1) ? DEPTH / 2 : 1);
          default: threshold = FULL_CNT;
        endcase
      end
    end
  endgenerate

  assign rxReady      = (countQ >= threshold);
  assign fillCount    = countQ;
  assign overflowFlag = ovfQ;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= FULL_CNT);

  assert_full_push_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && isFull) |=> ($stable(fillCount) && overflowFlag));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !ovfClear) |=> overflowFlag);

  assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !isEmpty) |=> $stable(fillCount));

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && isEmpty) |=> isEmpty);

  assert_top_sel_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && selHi && selLo) |-> isFull);

endmodule

// File: rtl/rx_trigger_fifo.sv
module rx_trigger_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxData,
  input  logic              hostPop,
  output logic [DATA_W-1:0] hostData,
  input  logic              trigSelHi,
  input  logic              trigSelLo,
  input  logic              ovfClear,
  output logic [CNT_W-1:0]  fillCount,
  output logic              isEmpty,
  output logic              isFull,
  output logic              overflowFlag,
  output logic              rxReady
);

  rxqStrobes_t stb;

  rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .push         (rxPush),
    .pop          (hostPop),
    .ovfClear     (ovfClear),
    .selHi        (trigSelHi),
    .selLo        (trigSelLo),
    .stb          (stb),
    .fillCount    (fillCount),
    .isEmpty      (isEmpty),
    .isFull       (isFull),
    .overflowFlag (overflowFlag),
    .rxReady      (rxReady)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (rxData),
    .rdData (hostData)
  );

endmodule

// File: tb/test_rx_trigger_fifo.sv
`timescale 1ns/1ps
module test_rx_trigger_fifo;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxPush = 1'b0;
  logic hostPop = 1'b0;
  logic selHi = 1'b0;
  logic selLo = 1'b0;
  logic ovfClear = 1'b0;
  logic [7:0] rxData = '0;

  logic [7:0] hostData8, hostData16;
  logic [3:0] fill8;
  logic [4:0] fill16;
  logic empty8, full8, ovf8, ready8;
  logic empty16, full16, ovf16, ready16;

  int errors = 0;
  int checks = 0;
  byte unsigned exp8[$];
  byte unsigned exp16[$];
  bit mOvf8 = 0;
  bit mOvf16 = 0;

  always #2 clk = ~clk;

  rx_trigger_fifo #(.DEPTH(8)) i_rx_trigger_fifo (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData),
    .hostPop(hostPop), .hostData(hostData8), .trigSelHi(selHi), .trigSelLo(selLo),
    .ovfClear(ovfClear), .fillCount(fill8), .isEmpty(empty8), .isFull(full8),
    .overflowFlag(ovf8), .rxReady(ready8));

  rx_trigger_fifo #(.DEPTH(16)) i_rx_trigger_fifo_d16 (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxData(rxData),
    .hostPop(hostPop), .hostData(hostData16), .trigSelHi(selHi), .trigSelLo(selLo),
    .ovfClear(ovfClear), .fillCount(fill16), .isEmpty(empty16), .isFull(full16),
    .overflowFlag(ovf16), .rxReady(ready16));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int thrOf(input int depth, input int sel);
    if (depth == 8) begin
      case (sel) 0: return 1; 1: return 3; 2: return 6; default: return 8; endcase
    end
    case (sel) 0: return 1; 1: return 6; 2: return 12; default: return 16; endcase
  endfunction

  task automatic checkState();
    chk(int'(fill8) == exp8.size(), "R3", "d8 fillCount", fill8, exp8.size());
    chk(empty8 == (exp8.size() == 0), "R3", "d8 isEmpty", empty8, exp8.size() == 0);
    chk(full8 == (exp8.size() == 8), "R3", "d8 isFull", full8, exp8.size() == 8);
    chk(ovf8 == mOvf8, "R7", "d8 overflowFlag", ovf8, mOvf8);
    chk(int'(fill16) == exp16.size(), "R3", "d16 fillCount", fill16, exp16.size());
    chk(empty16 == (exp16.size() == 0), "R3", "d16 isEmpty", empty16, exp16.size() == 0);
    chk(full16 == (exp16.size() == 16), "R3", "d16 isFull", full16, exp16.size() == 16);
    chk(ovf16 == mOvf16, "R7", "d16 overflowFlag", ovf16, mOvf16);
  endtask

  // Sweep all four selects without a clock edge (R6: combinational response)
  task automatic sweepReady();
    for (int s = 0; s < 4; s++) begin
      selHi = s[1];
      selLo = s[0];
      #1;
      chk(ready8 == (exp8.size() >= thrOf(8, s)), "R4", "d8 rxReady",
          ready8, exp8.size() >= thrOf(8, s));
      chk(ready16 == (exp16.size() >= thrOf(16, s)), "R5", "d16 rxReady",
          ready16, exp16.size() >= thrOf(16, s));
    end
    selHi = 1'b0;
    selLo = 1'b0;
  endtask

  // Driver plus monitor for one cycle; called at a falling edge
  task automatic step(input bit push, input byte unsigned data, input bit pop,
                      input bit clr);
    bit popOk, pushOk;
    rxPush = push; rxData = data; hostPop = pop; ovfClear = clr;
    #1;
    if (pop && exp8.size() > 0)
      chk(hostData8 == exp8[0], "R2", "d8 hostData", hostData8, exp8[0]);
    if (pop && exp16.size() > 0)
      chk(hostData16 == exp16[0], "R2", "d16 hostData", hostData16, exp16[0]);
    @(posedge clk);
    popOk = pop && exp8.size() > 0;
    pushOk = push && (exp8.size() < 8 || popOk);
    if (popOk) void'(exp8.pop_front());
    if (pushOk) exp8.push_back(data);
    if (push && !pushOk) mOvf8 = 1; else if (clr) mOvf8 = 0;
    popOk = pop && exp16.size() > 0;
    pushOk = push && (exp16.size() < 16 || popOk);
    if (popOk) void'(exp16.pop_front());
    if (pushOk) exp16.push_back(data);
    if (push && !pushOk) mOvf16 = 1; else if (clr) mOvf16 = 0;
    @(negedge clk);
    rxPush = 1'b0; hostPop = 1'b0; ovfClear = 1'b0;
    checkState();
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    exp8.delete(); exp16.delete();
    mOvf8 = 0; mOvf16 = 0;
    repeat (2) @(negedge clk);
    chk(fill8 == 0 && fill16 == 0, "R1", "fillCount zero", fill8 + fill16, 0);
    chk(empty8 && empty16, "R1", "isEmpty set", empty8 & empty16, 1);
    chk(!full8 && !full16, "R1", "isFull clear", full8 | full16, 0);
    chk(!ovf8 && !ovf16, "R1", "overflow clear", ovf8 | ovf16, 0);
    chk(!ready8 && !ready16, "R1", "rxReady clear", ready8 | ready16, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    applyReset();
    sweepReady();

    // R10: pop on empty ignored, then push+pop on empty stores the byte
    step(0, 8'h00, 1, 0);
    chk(fill8 == 0 && fill16 == 0, "R10", "count after empty pop", fill8 + fill16, 0);
    step(1, 8'h3C, 1, 0);
    chk(fill8 == 1 && fill16 == 1, "R10", "count after push+pop on empty", fill8, 1);
    step(0, 8'h00, 1, 0);

    // Fill: d8 overflows at the ninth push, d16 fills to 16 (R4, R5, R6, R7)
    for (int i = 0; i < 16; i++) begin
      step(1, 8'(8'h10 + i), 0, 0);
      sweepReady();
    end
    chk(ovf8 == 1 && ovf16 == 0, "R7", "d8 overflow only", {ovf8, ovf16}, 2);

    // R9: push and pop together while full
    step(1, 8'hA5, 1, 0);
    chk(fill8 == 8 && fill16 == 16 && ovf16 == 0, "R9", "full push+pop", fill16, 16);

    // R8: clear colliding with a new discard keeps the flag, then a lone clear
    step(1, 8'hEE, 0, 0);
    step(1, 8'hEF, 0, 1);
    chk(ovf8 && ovf16, "R8", "clear vs discard", {ovf8, ovf16}, 3);
    step(0, 8'h00, 0, 1);
    chk(!ovf8 && !ovf16, "R8", "lone clear", {ovf8, ovf16}, 0);

    // Drain with order checks (R2) and ready sweeps
    for (int i = 0; i < 17; i++) begin
      step(0, 8'h00, 1, 0);
      sweepReady();
    end

    // Mixed pattern
    for (int i = 0; i < 40; i++) begin
      step((i % 3) != 2, 8'(i * 7 + 1), (i % 4) == 3, 0);
    end
    sweepReady();

    // Reset with data stored
    applyReset();
    checkState();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule